// File: doc/BRIEF.md
# SPI baud-rate divider

This block turns the module clock into the timing strobes that an SPI master's frame engine needs to shift serial data. Two codes select the division. A 2-bit prescaler code picks one of four small odd factors, and a 4-bit scaler code picks a factor from a table that starts linearly and then doubles. The serial-clock period is the product of the two factors, counted in module-clock cycles.

While the run enable is high, the block emits two one-cycle strobes. The first is a half-period toggle strobe, which the frame engine uses to flip its serial clock line. The second is a bit-period strobe, which marks the end of each full serial-clock period. When the enable is low, the period counter is held cleared and both strobes stay low. A code change made while running does not cut a period short. It is picked up at the next period boundary.

Top module: `baud_div`

## Requirements
- R1: While reset is asserted, and afterwards until the run enable is sampled high, both strobes are low.
- R2: Prescaler codes 0, 1, 2 and 3 select factors 2, 3, 5 and 7. The period N in module-clock cycles is the prescaler factor times the scaler factor, so the smallest N is 4.
- R3: Scaler codes 0 to 3 select factors 2, 4, 6 and 8. Scaler codes 4 to 15 select 2 raised to the code, from 16 up to 32768.
- R4: Number the cycles from 0, where cycle 0 follows the first clock edge that samples the run enable high. The bit strobe is high for exactly one cycle in cycle N-1 and then in every N-th cycle after it.
- R5: The toggle strobe is high for one cycle in cycles ceil(N/2)-1 and N-1 of each period. It therefore coincides with every bit strobe.
- R6: A code change made while running leaves the current period at its old length. The new N applies from the next period onward.
- R7: From the cycle after an edge that samples the run enable low, both strobes are low, and they stay low while the enable stays low.
- R8: Raising the run enable again restarts the period from cycle 0, using the codes present at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable; low clears the divider |
| preCode | input | 2 | Prescaler code |
| sclCode | input | 4 | Scaler code |
| sckToggle | output | 1 | Half-period toggle strobe |
| bitTick | output | 1 | Bit-period strobe |

## Verification
The assertions take for granted that the codes are only ever decoded into a legal period of at least four cycles. They also assume that the codes are sampled only while the enable is low or at a period boundary, so the stored length cannot change partway through a period. The bench changes the codes at two points only: while the enable is low, and at a chosen point inside a running period to exercise the boundary rule. Every code combination it drives comes from the two tables. The longest case run, scaler code 15 with the smallest prescaler, gives one full 65536-cycle period inside the time budget.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  localparam int PRE_W = 2;
  localparam int SCL_W = 4;
  // largest period 7 * 2**((1<<SCL_W)-1) fits in this many bits
  localparam int CNT_W = (1 << SCL_W) + 3;
  localparam int MIN_LEN = 4;

  typedef struct packed {
    logic clear;
    logic load;
    logic advance;
  } divCtrlT;

  function automatic logic [CNT_W-1:0] preFactor(input logic [PRE_W-1:0] c);
    case (c)
      2'd0:    return CNT_W'(2);
      2'd1:    return CNT_W'(3);
      2'd2:    return CNT_W'(5);
      default: return CNT_W'(7);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] scaleFactor(input logic [SCL_W-1:0] c);
    if (c < SCL_W'(4)) return (CNT_W'(c) + CNT_W'(1)) << 1;
    else               return CNT_W'(1) << c;
  endfunction

  function automatic logic [CNT_W-1:0] divLen(input logic [PRE_W-1:0] p,
                                              input logic [SCL_W-1:0] s);
    logic [CNT_W-1:0] a;
    logic [CNT_W-1:0] b;
    a = preFactor(p);
    b = scaleFactor(s);
    return a * b;
  endfunction
endpackage

// File: rtl/baud_div_path.sv
module baud_div_path import baud_div_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  divCtrlT          ctrl,
  input  logic [PRE_W-1:0] preCode,
  input  logic [SCL_W-1:0] sclCode,
  output logic             halfHit,
  output logic             fullHit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lenFull;
  logic [CNT_W-1:0] lenHalf;
  logic [CNT_W-1:0] nextLen;

  always_comb nextLen = divLen(preCode, sclCode);

  assign fullHit = (cnt == lenFull - CNT_W'(1));
  assign halfHit = (cnt == lenHalf - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      lenFull <= CNT_W'(MIN_LEN);
      lenHalf <= CNT_W'(MIN_LEN / 2);
    end else begin
      if (ctrl.clear)        cnt <= '0;
      else if (ctrl.advance) cnt <= fullHit ? '0 : cnt + CNT_W'(1);
      if (ctrl.load) begin
        lenFull <= nextLen;
        lenHalf <= (nextLen + CNT_W'(1)) >> 1;
      end
    end
  end

  // R4: the count never reaches the stored period length
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt < lenFull);

  // R2: a stored period is never shorter than the smallest legal product
  assert_len_min_R2: assert property (@(posedge clk) disable iff (!rstN)
    lenFull >= CNT_W'(MIN_LEN));

  // R6: inside a running period the length does not move
  assert_len_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && !fullHit) |=> $stable(lenFull));
endmodule

// File: rtl/baud_div_ctrl.sv
module baud_div_ctrl import baud_div_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    runEn,
  input  logic    halfHit,
  input  logic    fullHit,
  output divCtrlT ctrl,
  output logic    tglTick,
  output logic    bitTick
);
  always_comb begin
    ctrl.clear   = !runEn;
    ctrl.advance = runEn;
    ctrl.load    = !runEn || fullHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tglTick <= 1'b0;
      bitTick <= 1'b0;
    end else begin
      tglTick <= runEn && (halfHit || fullHit);
      bitTick <= runEn && fullHit;
    end
  end

  // R7: a low enable silences both strobes on the next cycle
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!tglTick && !bitTick));

  // R4: period is at least four cycles, so bit strobes never sit back to back
  assert_bit_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);
endmodule

// File: rtl/baud_div.sv
module baud_div import baud_div_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [PRE_W-1:0] preCode,
  input  logic [SCL_W-1:0] sclCode,
  output logic             sckToggle,
  output logic             bitTick
);
  divCtrlT ctrl;
  logic    halfHit;
  logic    fullHit;

  baud_div_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .halfHit(halfHit), .fullHit(fullHit),
    .ctrl(ctrl), .tglTick(sckToggle), .bitTick(bitTick)
  );

  baud_div_path uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .preCode(preCode), .sclCode(sclCode),
    .halfHit(halfHit), .fullHit(fullHit)
  );
endmodule

// File: tb/tb_baud_div.sv
`timescale 1ns/1ps
module tb_baud_div;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic [1:0] preCode = '0;
  logic [3:0] sclCode = '0;
  logic       sckToggle;
  logic       bitTick;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  baud_div dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .preCode(preCode),
    .sclCode(sclCode), .sckToggle(sckToggle), .bitTick(bitTick)
  );

  function automatic int preV(input int c);
    case (c)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int sclV(input int c);
    return (c < 4) ? 2 * (c + 1) : (1 << c);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expBit(input int m, input int n);
    return m == n - 1;
  endfunction

  function automatic bit expTgl(input int m, input int n);
    return (m == n - 1) || (m == (n + 1) / 2 - 1);
  endfunction

  task automatic runPattern(input int pre, input int scl, input int periods, input string req);
    int n;
    int bad;
    int firstBad;
    int bits;
    n = preV(pre) * sclV(scl);
    bad = 0; firstBad = -1; bits = 0;
    runEn = 1'b0;
    @(negedge clk);
    preCode = 2'(pre); sclCode = 4'(scl);
    @(negedge clk);
    runEn = 1'b1;
    for (int k = 0; k < periods * n; k++) begin
      @(negedge clk);
      if (sckToggle !== expTgl(k % n, n) || bitTick !== expBit(k % n, n)) begin
        bad++;
        if (firstBad < 0) firstBad = k;
      end
      if (bitTick === 1'b1) bits++;
    end
    runEn = 1'b0;
    check(bad == 0, {req, " strobe timing mismatches"}, bad, 0);
    check(bits == periods, {req, " bit strobe count"}, bits, periods);
  endtask

  task automatic testReset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(sckToggle === 1'b0 && bitTick === 1'b0, "R1 strobes in reset", {sckToggle, bitTick}, 0);
    end
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(sckToggle === 1'b0 && bitTick === 1'b0, "R1 strobes idle after reset", {sckToggle, bitTick}, 0);
    end
  endtask

  task automatic testMidChange();
    int bad;
    int n;
    int m;
    bad = 0;
    runEn = 1'b0;
    preCode = 2'd0; sclCode = 4'd0;
    @(negedge clk);
    runEn = 1'b1;
    for (int k = 0; k < 28; k++) begin
      @(negedge clk);
      if (k < 4) begin n = 4; m = k; end
      else begin n = 12; m = (k - 4) % 12; end
      if (sckToggle !== expTgl(m, n) || bitTick !== expBit(m, n)) bad++;
      if (k == 1) begin preCode = 2'd1; sclCode = 4'd1; end
    end
    runEn = 1'b0;
    check(bad == 0, "R6 code change at period boundary", bad, 0);
  endtask

  task automatic testDisable();
    int highs;
    highs = 0;
    runEn = 1'b0;
    preCode = 2'd0; sclCode = 4'd0;
    @(negedge clk);
    runEn = 1'b1;
    for (int k = 0; k < 6; k++) @(negedge clk);
    runEn = 1'b0;
    preCode = 2'd1; sclCode = 4'd0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (sckToggle !== 1'b0 || bitTick !== 1'b0) highs++;
    end
    check(highs == 0, "R7 strobes low while disabled", highs, 0);
    runPattern(1, 0, 3, "R8 restart with new codes");
  endtask

  initial begin
    testReset();
    runPattern(0, 0, 4, "R2 R3 R4 R5 pre0 scl0");
    runPattern(1, 0, 4, "R2 R3 R4 R5 pre1 scl0");
    runPattern(2, 1, 3, "R2 R3 R4 R5 pre2 scl1");
    runPattern(3, 2, 2, "R2 R3 R4 R5 pre3 scl2");
    runPattern(1, 3, 2, "R3 R4 R5 pre1 scl3");
    runPattern(0, 4, 2, "R3 R4 R5 pre0 scl4");
    runPattern(3, 8, 1, "R2 R3 R4 pre3 scl8");
    runPattern(0, 15, 1, "R3 R4 pre0 scl15");
    testMidChange();
    testDisable();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule